// File: doc/BRIEF.md
# Parallel I/O Port with Edge-Capture Interrupt

This block is a general-purpose pin port of up to 32 pins, controlled through a small register bus. A register bus has a write strobe, a read strobe, a two-bit word index, a 32-bit write word and a 32-bit read word. Each pin has an output latch and a direction bit. Each pin also has an interrupt enable bit and a sticky capture bit. Pin inputs are resynchronised to the block clock before any logic uses them.

The interrupt trigger is fixed at build time by a parameter, and takes one of four values: rising edge, falling edge, either edge, or level high. In the three edge modes, a qualifying transition on a pin sets that pin's capture bit. The bit stays set until software writes a one to it. The single interrupt line is high while any captured pin is also enabled. In level mode there is no capture. The line follows the enabled pins' current data directly.

The bus carries single-word register accesses. It has no back-pressure: every access completes in one cycle, and no ready signal exists. A write takes effect at the clock edge where the write strobe is seen. A read returns its word on `bus_rdata` from the edge where the read strobe is seen, and holds it until the next read. The word index selects a register: 0 is pin data, 1 is direction, 2 is interrupt enable, and 3 is capture.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the output latch, direction, enable and capture registers are all zero, so `pin_oe`, `pin_out` and `irq` are low.
- R2: Writing index 1 sets the direction register; `pin_oe` bit n follows it from the next cycle (1 = pin driven, 0 = pin sampled).
- R3: Writing index 0 updates only the output latch, which drives `pin_out` whatever the direction. Reading index 0 returns the latch bit for output pins and the synchronised input level for input pins.
- R4: A read issued in the first or second cycle after an input pin changes returns the old level. A read issued in the third cycle returns the new level.
- R5: In an edge mode, a capture bit becomes set only on that pin's qualifying transition: low-to-high for rising, high-to-low for falling, or either for both. The transition is detected between two consecutive synchronised samples. The enable bit does not affect capture.
- R6: A captured pin's transition sets its capture bit at the third rising clock edge after the pin changes. With the pin enabled, `irq` rises in that same cycle.
- R7: Writing index 3 clears each capture bit written as 1 and leaves bits written as 0 unchanged.
- R8: When a qualifying transition and a clear of the same capture bit meet in one cycle, the bit stays set.
- R9: In an edge mode, `irq` is high exactly while (capture AND enable) is nonzero.
- R10: In level mode, `irq` is high while (pin data AND enable) is nonzero and drops as soon as the pin falls; index 3 reads zero.
- R11: Register bits at and above the pin count read as zero.
- R12: With enable bits clear, `irq` stays low even when capture bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word index: 0 data, 1 direction, 2 enable, 3 capture |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, registered on a read strobe |
| pin_in | input | NPINS | Raw pin levels from the pads |
| pin_out | output | NPINS | Output latch value |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Interrupt request to the host |

## Verification
Several properties are checked on every cycle. The direction and output-latch writes must reach `pin_oe` and `pin_out` one cycle later, and `pin_out` must not move without a write. In the edge modes, capture bits may only appear where a qualifying transition was seen, and may only vanish where a one was written to clear them. A transition that coincides with its clear must leave the bit set. `irq` must stay low while every enable bit is clear. Other behaviour can only be shown by the directed scenarios: the three-cycle latency from pin to capture and interrupt, the two-cycle read latency of the synchroniser, the mixed read-back of input and output pins, the level mode dropping its interrupt without latching, and the zero upper bits with a narrow pin count.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 2;
  localparam int MAX_PINS = 32;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  typedef enum logic [ADDR_W-1:0] {
    IDX_DATA = 2'd0,
    IDX_DIR  = 2'd1,
    IDX_EN   = 2'd2,
    IDX_CAP  = 2'd3
  } reg_idx_e;

  function automatic logic trig_is_edge(trig_e t);
    return t != TRIG_LEVEL;
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced,
  output logic [W-1:0] delayed
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= raw;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign synced  = stage_q[STAGES-1];
  assign delayed = stage_q[STAGES];
endmodule

// File: rtl/gpio_capture.sv
module gpio_capture
  import gpio_edge_irq_pkg::*;
#(
  parameter int    W    = 32,
  parameter trig_e TRIG = TRIG_RISE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] now_lvl,
  input  logic [W-1:0] old_lvl,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] hit,
  output logic [W-1:0] cap
);
  generate
    if (TRIG == TRIG_LEVEL) begin : g_level
      assign hit = '0;
      assign cap = '0;
    end else begin : g_edge
      logic [W-1:0] cap_q;
      if (TRIG == TRIG_RISE) begin : g_rise
        assign hit = now_lvl & ~old_lvl;
      end else if (TRIG == TRIG_FALL) begin : g_fall
        assign hit = ~now_lvl & old_lvl;
      end else begin : g_both
        assign hit = now_lvl ^ old_lvl;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr_mask) | hit;
      end
      assign cap = cap_q;
    end
  endgenerate
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_edge_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] idx,
  input  logic [W-1:0]      wval,
  output logic [W-1:0]      out_latch,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      en,
  output logic [W-1:0]      cap_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_latch <= '0;
      dir       <= '0;
      en        <= '0;
    end else if (wr) begin
      case (reg_idx_e'(idx))
        IDX_DATA: out_latch <= wval;
        IDX_DIR:  dir       <= wval;
        IDX_EN:   en        <= wval;
        default:  ;
      endcase
    end
  end

  assign cap_clr = (wr && reg_idx_e'(idx) == IDX_CAP) ? wval : '0;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_irq_pkg::*;
#(
  parameter int    NPINS = 32,
  parameter trig_e TRIG  = TRIG_RISE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int SYNC_STAGES = 2;

  logic [NPINS-1:0] lvl_now, lvl_old;
  logic [NPINS-1:0] out_q, dir_q, mask_q, clr_vec;
  logic [NPINS-1:0] cap_q, edge_hit;
  logic [NPINS-1:0] data_view;
  logic [BUS_W-1:0] rd_word;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata;

  gpio_pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in),
    .synced(lvl_now), .delayed(lvl_old)
  );

  gpio_ctrl_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .idx(bus_addr),
    .wval(bus_wdata[NPINS-1:0]),
    .out_latch(out_q), .dir(dir_q), .en(mask_q), .cap_clr(clr_vec)
  );

  gpio_capture #(.W(NPINS), .TRIG(TRIG)) u_cap (
    .clk(clk), .rst_n(rst_n), .now_lvl(lvl_now), .old_lvl(lvl_old),
    .clr_mask(clr_vec), .hit(edge_hit), .cap(cap_q)
  );

  assign data_view = (lvl_now & ~dir_q) | (out_q & dir_q);

  always_comb begin
    rd_word = '0;
    case (reg_idx_e'(bus_addr))
      IDX_DATA: rd_word[NPINS-1:0] = data_view;
      IDX_DIR:  rd_word[NPINS-1:0] = dir_q;
      IDX_EN:   rd_word[NPINS-1:0] = mask_q;
      default:  rd_word[NPINS-1:0] = cap_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  generate
    if (trig_is_edge(TRIG)) begin : g_irq_edge
      assign irq = |(cap_q & mask_q);
    end else begin : g_irq_level
      assign irq = |(data_view & mask_q);
    end
  endgenerate

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_edge_irq_pkg::*;
#(
  parameter int    NPINS = 32,
  parameter trig_e TRIG  = TRIG_RISE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  cap,
  input logic [NPINS-1:0]  hit,
  input logic [NPINS-1:0]  mask
);
  logic [NPINS-1:0] clr_seen;
  assign clr_seen = (bus_wr && bus_addr == IDX_CAP) ? bus_wdata[NPINS-1:0] : '0;

  initial begin
    AST_PIN_COUNT: assert (NPINS >= 1 && NPINS <= MAX_PINS); // R11
  end

  AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == IDX_DIR) |=> pin_oe == $past(bus_wdata[NPINS-1:0])); // R2

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == IDX_DATA) |=> pin_out == $past(bus_wdata[NPINS-1:0])); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == IDX_DATA) |=> $stable(pin_out)); // R3

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R12

  generate
    if (trig_is_edge(TRIG)) begin : g_edge_props
      AST_CAP_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap & ~$past(cap) & ~$past(hit)) == '0)); // R5

      AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap & $past(cap & ~clr_seen)) == $past(cap & ~clr_seen))); // R7

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((cap & $past(hit)) == $past(hit))); // R8
    end
  endgenerate
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPINS(NPINS), .TRIG(TRIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .cap(cap_q), .hit(edge_hit), .mask(mask_q)
);

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;
  import gpio_edge_irq_pkg::*;

  localparam int N = 12;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [N-1:0] pin_in = '0;
  logic [31:0] rdata [NI];
  logic [N-1:0] pout [NI];
  logic [N-1:0] poe [NI];
  logic irq [NI];
  logic [31:0] rd_v [NI];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_edge_irq #(.NPINS(N), .TRIG(TRIG_RISE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .pin_in(pin_in),
    .pin_out(pout[0]), .pin_oe(poe[0]), .irq(irq[0]));
  gpio_edge_irq #(.NPINS(N), .TRIG(TRIG_FALL)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .pin_in(pin_in),
    .pin_out(pout[1]), .pin_oe(poe[1]), .irq(irq[1]));
  gpio_edge_irq #(.NPINS(N), .TRIG(TRIG_BOTH)) u2 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[2]), .pin_in(pin_in),
    .pin_out(pout[2]), .pin_oe(poe[2]), .irq(irq[2]));
  gpio_edge_irq #(.NPINS(N), .TRIG(TRIG_LEVEL)) u3 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[3]), .pin_in(pin_in),
    .pin_out(pout[3]), .pin_oe(poe[3]), .irq(irq[3]));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Caller stands on a negedge; the write lands at the next posedge.
  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    for (int i = 0; i < NI; i++) rd_v[i] = rdata[i];
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    pin_in = '0;
    idle(4);
    bus_write(IDX_CAP, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NI; i++) begin
      chk(32'(poe[i]), 0, "R1 pin_oe after reset");
      chk(32'(pout[i]), 0, "R1 pin_out after reset");
      chk(32'(irq[i]), 0, "R1 irq after reset");
    end
    bus_read(IDX_DIR);  chk(rd_v[0], 0, "R1 direction reads zero");
    bus_read(IDX_EN);   chk(rd_v[0], 0, "R1 enable reads zero");
    bus_read(IDX_CAP);  chk(rd_v[2], 0, "R1 capture reads zero");
    bus_read(IDX_DATA); chk(rd_v[0], 0, "R1 data reads zero");
  endtask

  task automatic t_regs();
    bus_write(IDX_DIR, 32'hFFFF_FFFF);
    chk(32'(poe[0]), 32'hFFF, "R2 pin_oe follows direction");
    bus_read(IDX_DIR); chk(rd_v[0], 32'h0000_0FFF, "R11 upper direction bits read zero");
    bus_write(IDX_DATA, 32'hFFFF_FA5A);
    chk(32'(pout[1]), 32'hA5A, "R3 pin_out follows latch");
    bus_read(IDX_DATA); chk(rd_v[0], 32'h0000_0A5A, "R3/R11 output pins read latch");
    bus_write(IDX_DIR, 32'h0F0);
    chk(32'(poe[0]), 32'h0F0, "R2 partial direction");
    pin_in = 12'h30F;
    idle(3);
    bus_read(IDX_DATA); chk(rd_v[0], 32'h35F, "R3 mixed input/output read");
    bus_write(IDX_DIR, 32'h0);
    bus_write(IDX_DATA, 32'h3C3);
    chk(32'(pout[0]), 32'h3C3, "R3 latch written while pins are inputs");
    chk(32'(poe[0]), 0, "R2 all pins inputs");
    clear_all();
    bus_read(IDX_CAP);
    for (int i = 0; i < NI; i++) chk(rd_v[i], 0, "R7 full clear");
  endtask

  task automatic t_sync();
    pin_in = 12'h001;
    bus_read(IDX_DATA); chk(rd_v[0], 32'h3C0 & 32'h0, "R4 first cycle old level");
    bus_read(IDX_DATA); chk(rd_v[0], 0, "R4 second cycle old level");
    bus_read(IDX_DATA); chk(rd_v[0], 1, "R4 third cycle new level");
    clear_all();
  endtask

  task automatic t_edges();
    bus_write(IDX_EN, 32'h0);
    pin_in = 12'h002;
    idle(4);
    chk(32'(irq[0]), 0, "R12 captured but disabled");
    bus_read(IDX_CAP);
    chk(rd_v[0], 32'h002, "R5 rising captured");
    chk(rd_v[1], 32'h000, "R5 falling ignores rise");
    chk(rd_v[2], 32'h002, "R5 both captures rise");
    chk(rd_v[3], 32'h000, "R10 level reads no capture");
    bus_write(IDX_EN, 32'h002);
    chk(32'(irq[0]), 1, "R9 rising irq");
    chk(32'(irq[1]), 0, "R9 falling no irq");
    chk(32'(irq[2]), 1, "R9 both irq");
    chk(32'(irq[3]), 1, "R10 level irq high");
    pin_in = 12'h000;
    idle(4);
    chk(32'(irq[0]), 1, "R9 rising irq sticky");
    chk(32'(irq[1]), 1, "R5 falling captured");
    chk(32'(irq[3]), 0, "R10 level irq drops");
    bus_write(IDX_CAP, 32'h001);
    bus_read(IDX_CAP);
    chk(rd_v[0], 32'h002, "R7 zero-bit write keeps capture");
    bus_write(IDX_CAP, 32'h002);
    bus_read(IDX_CAP);
    chk(rd_v[0], 0, "R7 one-bit write clears");
    chk(32'(irq[0]), 0, "R9 irq low after clear");
    chk(32'(irq[2]), 0, "R9 both irq low after clear");
  endtask

  task automatic t_latency();
    bus_write(IDX_EN, 32'h004);
    pin_in = 12'h004;
    idle(2);
    chk(32'(irq[0]), 0, "R6 irq not yet at second edge");
    idle(1);
    chk(32'(irq[0]), 1, "R6 irq at third edge");
    clear_all();
  endtask

  task automatic t_set_wins();
    pin_in = 12'h008; idle(4);
    pin_in = 12'h000; idle(4);
    pin_in = 12'h008;
    idle(2);
    bus_write(IDX_CAP, 32'h008);
    bus_read(IDX_CAP);
    chk(rd_v[0], 32'h008, "R8 rising set beats clear");
    chk(rd_v[1], 32'h000, "R7 clear without transition");
    chk(rd_v[2], 32'h008, "R8 both set beats clear");
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_sync();
    t_edges();
    t_latency();
    t_set_wins();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule